// File: doc/BRIEF.md
# DRAM Fast-Access Controller

This block is the sequencing state machine of an external DRAM controller for a single processor bus. For every bus cycle it decides whether the row already held open can be reused. A reused row gives a fast access with only a column strobe. Otherwise the block performs a full access: row strobe, a programmable row-to-column delay, then the column strobe. It returns a one-cycle transfer acknowledge when the data phase begins.

Between bus cycles the block keeps the row strobe asserted so that the next access can take the fast path. In static-column mode it also keeps the column strobe asserted. A down-counter, loaded with a programmable limit whenever a row opens, closes an idle row before the row strobe exceeds its maximum low time. Refresh ticks are latched and serviced at the end of a bus cycle, from idle, or from a held row. Refresh uses a column-before-row sequence, and the next access after any refresh always reopens the row, whatever the page-hit flag says.

Top module: `dram_fastpath_ctrl`

## Requirements
- R1: While `rst_n` is low, and after release until a request arrives, `ras_act`, `cas_act`, `xfer_ack` and `ref_busy` are all 0.
- R2: A full access raises `ras_act` in the cycle after the edge that samples `cyc_start`. `cas_act` and `xfer_ack` rise `rcd_clks` cycles later, so `xfer_ack` is seen `rcd_clks`+1 cycles after the start edge. `xfer_ack` is high for exactly one cycle.
- R3: With a row held, `page_hit`=1 and `fast_mode` not 00, an access is fast. `xfer_ack` and `cas_act` are high in the cycle after the start edge, and `ras_act` stays high throughout.
- R4: With a row held and `page_hit`=0, `ras_act` drops for one cycle and a full access follows. `xfer_ack` is seen `rcd_clks`+2 cycles after the start edge.
- R5: `fast_mode` is encoded as 00 full-only, 01 page, 10 nibble and 11 static column. After `cyc_end` in modes 01 and 10, `ras_act` stays 1 and `cas_act` goes 0. In mode 11 both stay 1. In mode 00 both go 0, and `page_hit` has no effect on the next access.
- R6: Opening a row loads `ras_limit`. If the row sits idle, `ras_act` is high for exactly `ras_limit`+1 cycles counted from the opening. After the row closes, `page_hit`=1 still yields a full access.
- R7: A `ref_tick` pulse is held pending until the refresh starts and is never lost. A tick during an active bus cycle starts the refresh in the cycle right after `cyc_end`. A tick while a row is held starts the refresh two cycles after the tick edge.
- R8: A refresh keeps `ref_busy` high for REF_LEN+1 cycles. `cas_act` is high in all of them. `ras_act` is low in the first and high in the remaining REF_LEN. Afterwards both strobes are released.
- R9: `xfer_ack` never rises while `ref_busy` is high. An access started during a refresh completes after it, with `xfer_ack` seen REF_LEN+`rcd_clks`+2 cycles after the start edge when it starts in the first refresh cycle.
- R10: The first access after a refresh is a full access even with `page_hit`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a two-flop synchronizer |
| cyc_start | input | 1 | One-cycle pulse: a bus cycle begins |
| cyc_end | input | 1 | One-cycle pulse: the processor ends the current bus cycle |
| page_hit | input | 1 | Row comparator result for the pending access |
| ref_tick | input | 1 | One-cycle refresh request |
| fast_mode | input | 2 | Fast-access mode (00 full, 01 page, 10 nibble, 11 static column) |
| rcd_clks | input | RCD_W | Row-to-column delay in cycles, at least 1 |
| ras_limit | input | CNT_W | Row-open limit in cycles |
| ras_act | output | 1 | Row strobe, active high |
| cas_act | output | 1 | Column strobe, active high |
| xfer_ack | output | 1 | Transfer acknowledge, one cycle per access |
| ref_busy | output | 1 | Refresh sequence in progress |

## Verification
The assertions take for granted that the bus has at most one access outstanding. They also assume that `cyc_end` arrives only after `xfer_ack` and that `rcd_clks` is at least 1. The mutual exclusion of acknowledge and refresh, and the column-before-row check, rely on `ref_tick` being a single-cycle pulse. The stimulus starts each access only once the previous cycle has ended. It raises `cyc_end` one cycle after the acknowledge and changes `ras_limit` or `fast_mode` only between accesses. It pulses `ref_tick` for one cycle at a time, and keeps `ras_limit` well above the length of one access.

// File: rtl/dfa_pkg.sv
package dfa_pkg;

  typedef enum logic [1:0] {
    FM_NONE   = 2'b00,
    FM_PAGE   = 2'b01,
    FM_NIBBLE = 2'b10,
    FM_STATIC = 2'b11
  } fmode_e;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_ROW  = 3'd1,
    ST_COL  = 3'd2,
    ST_DATA = 3'd3,
    ST_HOLD = 3'd4,
    ST_REF  = 3'd5
  } seq_st_e;

endpackage

// File: rtl/dfa_rst_sync.sv
module dfa_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_n_out = sync_q[1];

endmodule

// File: rtl/dfa_req_hold.sv
// Sticky request flags: bus access and refresh.
module dfa_req_hold (
  input  logic clk,
  input  logic rst_n,
  input  logic cyc_start,
  input  logic ref_tick,
  input  logic acc_take,
  input  logic ref_take,
  output logic acc_req,
  output logic ref_pend
);

  logic acc_q, acc_d, acc_en;
  logic ref_q, ref_d, ref_en;

  always_comb begin
    acc_d  = (acc_q | cyc_start) & ~acc_take;
    acc_en = cyc_start | acc_take;
    ref_d  = (ref_q & ~ref_take) | ref_tick;
    ref_en = ref_tick | ref_take;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= 1'b0;
      ref_q <= 1'b0;
    end else begin
      if (acc_en) acc_q <= acc_d;
      if (ref_en) ref_q <= ref_d;
    end
  end

  assign acc_req  = acc_q | cyc_start;
  assign ref_pend = ref_q;

endmodule

// File: rtl/dfa_row_guard.sv
// Open-row tracking and row-strobe low-time guard.
module dfa_row_guard
  import dfa_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             open_row,
  input  logic             row_drop,
  input  logic [CNT_W-1:0] ras_limit,
  input  logic             page_hit,
  input  fmode_e           mode,
  output logic             row_valid,
  output logic             tmo,
  output logic             fast_ok
);

  logic [CNT_W-1:0] tmr_q, tmr_d;
  logic             tmr_en;
  logic             vld_q, vld_d;
  logic             tmr_zero;

  assign tmr_zero = (tmr_q == '0);

  always_comb begin
    tmr_en = open_row | (vld_q & ~tmr_zero);
    tmr_d  = open_row ? ras_limit : (tmr_q - CNT_W'(1));
    if (open_row) begin
      vld_d = 1'b1;
    end else if (row_drop) begin
      vld_d = 1'b0;
    end else begin
      vld_d = vld_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr_q <= '0;
      vld_q <= 1'b0;
    end else begin
      if (tmr_en) tmr_q <= tmr_d;
      vld_q <= vld_d;
    end
  end

  assign row_valid = vld_q;
  assign tmo       = vld_q & tmr_zero;
  assign fast_ok   = vld_q & ~tmr_zero & page_hit & (mode != FM_NONE);

endmodule

// File: rtl/dfa_seq_fsm.sv
// Access / hold / refresh sequencer.
module dfa_seq_fsm
  import dfa_pkg::*;
#(
  parameter int RCD_W   = 3,
  parameter int REF_LEN = 3,
  parameter int SEQ_W   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_req,
  input  logic             ref_req,
  input  logic             cyc_end,
  input  logic             fast_ok,
  input  logic             tmo,
  input  fmode_e           mode,
  input  logic [RCD_W-1:0] rcd_clks,
  output logic             acc_take,
  output logic             ref_take,
  output logic             open_row,
  output logic             row_drop,
  output logic             hold_st,
  output logic             ras,
  output logic             cas,
  output logic             ta,
  output logic             ref_busy
);

  seq_st_e          st_q, st_d;
  logic [SEQ_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             row_done, ref_done;

  assign row_done = (cnt_q + SEQ_W'(1)) >= SEQ_W'(rcd_clks);
  assign ref_done = (cnt_q == SEQ_W'(REF_LEN));

  always_comb begin
    st_d     = st_q;
    acc_take = 1'b0;
    ref_take = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (ref_req) begin
          st_d     = ST_REF;
          ref_take = 1'b1;
        end else if (acc_req) begin
          st_d     = ST_ROW;
          acc_take = 1'b1;
        end
      end
      ST_ROW: begin
        if (row_done) st_d = ST_COL;
      end
      ST_COL: st_d = ST_DATA;
      ST_DATA: begin
        if (cyc_end) begin
          if (ref_req) begin
            st_d     = ST_REF;
            ref_take = 1'b1;
          end else if (mode == FM_NONE) begin
            st_d = ST_IDLE;
          end else begin
            st_d = ST_HOLD;
          end
        end
      end
      ST_HOLD: begin
        if (ref_req) begin
          st_d     = ST_REF;
          ref_take = 1'b1;
        end else if (tmo) begin
          st_d = ST_IDLE;
        end else if (acc_req) begin
          if (fast_ok) begin
            st_d     = ST_COL;
            acc_take = 1'b1;
          end else begin
            st_d = ST_IDLE;
          end
        end
      end
      ST_REF: begin
        if (ref_done) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_comb begin
    cnt_en = (st_d != st_q) | (st_q == ST_ROW) | (st_q == ST_REF);
    cnt_d  = (st_d != st_q) ? '0 : (cnt_q + SEQ_W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      st_q <= st_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign open_row = (st_q == ST_IDLE) && (st_d == ST_ROW);
  assign row_drop = (st_d == ST_IDLE) || (st_d == ST_REF);
  assign hold_st  = (st_q == ST_HOLD);

  always_comb begin
    ras      = 1'b0;
    cas      = 1'b0;
    ta       = 1'b0;
    ref_busy = 1'b0;
    unique case (st_q)
      ST_ROW:  ras = 1'b1;
      ST_COL:  begin ras = 1'b1; cas = 1'b1; ta = 1'b1; end
      ST_DATA: begin ras = 1'b1; cas = 1'b1; end
      ST_HOLD: begin ras = 1'b1; cas = (mode == FM_STATIC); end
      ST_REF:  begin ref_busy = 1'b1; cas = 1'b1; ras = (cnt_q != '0); end
      default: ;
    endcase
  end

endmodule

// File: rtl/dram_fastpath_ctrl.sv
module dram_fastpath_ctrl
  import dfa_pkg::*;
#(
  parameter int CNT_W   = 8,
  parameter int RCD_W   = 3,
  parameter int REF_LEN = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cyc_start,
  input  logic             cyc_end,
  input  logic             page_hit,
  input  logic             ref_tick,
  input  logic [1:0]       fast_mode,
  input  logic [RCD_W-1:0] rcd_clks,
  input  logic [CNT_W-1:0] ras_limit,
  output logic             ras_act,
  output logic             cas_act,
  output logic             xfer_ack,
  output logic             ref_busy
);

  localparam int REF_W = $clog2(REF_LEN + 1);
  localparam int SEQ_W = ((RCD_W > REF_W) ? RCD_W : REF_W) + 1;

  fmode_e mode;
  logic   rst_n_s;
  logic   acc_req, ref_pend, acc_take, ref_take;
  logic   open_row, row_drop, hold_st;
  logic   row_valid, tmo, fast_ok;
  logic   mode_sc;

  assign mode    = fmode_e'(fast_mode);
  assign mode_sc = (mode == FM_STATIC);

  dfa_rst_sync u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_s)
  );

  dfa_req_hold u_req (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .cyc_start (cyc_start),
    .ref_tick  (ref_tick),
    .acc_take  (acc_take),
    .ref_take  (ref_take),
    .acc_req   (acc_req),
    .ref_pend  (ref_pend)
  );

  dfa_row_guard #(.CNT_W(CNT_W)) u_guard (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .open_row  (open_row),
    .row_drop  (row_drop),
    .ras_limit (ras_limit),
    .page_hit  (page_hit),
    .mode      (mode),
    .row_valid (row_valid),
    .tmo       (tmo),
    .fast_ok   (fast_ok)
  );

  dfa_seq_fsm #(.RCD_W(RCD_W), .REF_LEN(REF_LEN), .SEQ_W(SEQ_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .acc_req  (acc_req),
    .ref_req  (ref_pend),
    .cyc_end  (cyc_end),
    .fast_ok  (fast_ok),
    .tmo      (tmo),
    .mode     (mode),
    .rcd_clks (rcd_clks),
    .acc_take (acc_take),
    .ref_take (ref_take),
    .open_row (open_row),
    .row_drop (row_drop),
    .hold_st  (hold_st),
    .ras      (ras_act),
    .cas      (cas_act),
    .ta       (xfer_ack),
    .ref_busy (ref_busy)
  );

endmodule

// File: rtl/dfa_chk.sv
module dfa_chk (
  input logic clk,
  input logic rst_n,
  input logic ras,
  input logic cas,
  input logic ta,
  input logic ref_busy,
  input logic ref_pend,
  input logic row_valid,
  input logic hold_st,
  input logic tmo,
  input logic mode_sc
);

  // R9
  ta_ref_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ta && ref_busy));

  // R2
  ta_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ta |=> !ta);

  // R8
  ref_cbr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ref_busy) |-> (cas && !ras));

  // R7
  ref_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_pend && !ref_busy) |=> (ref_pend || ref_busy));

  // R6
  tmo_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_st && tmo) |=> !ras);

  // R5
  hold_cas_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_st && !mode_sc) |-> !cas);

  // R10
  ref_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ref_busy) |-> !row_valid);

endmodule

bind dram_fastpath_ctrl dfa_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ras       (ras_act),
  .cas       (cas_act),
  .ta        (xfer_ack),
  .ref_busy  (ref_busy),
  .ref_pend  (ref_pend),
  .row_valid (row_valid),
  .hold_st   (hold_st),
  .tmo       (tmo),
  .mode_sc   (mode_sc)
);

// File: tb/test_dram_fastpath_ctrl.sv
`timescale 1ns/1ps
module test_dram_fastpath_ctrl;

  localparam int CNT_W   = 8;
  localparam int RCD_W   = 3;
  localparam int REF_LEN = 3;
  localparam int RCD     = 2;
  localparam int NVEC    = 10;

  // Table: mode, page_hit, expected ack latency, ras and cas after cycle end.
  localparam int V_MODE [NVEC] = '{1, 1, 1, 3, 3, 2, 0, 0, 2, 2};
  localparam int V_HIT  [NVEC] = '{1, 1, 0, 1, 1, 1, 1, 1, 1, 0};
  localparam int V_LAT  [NVEC] = '{3, 1, 4, 1, 1, 1, 4, 3, 3, 4};
  localparam int V_RAS  [NVEC] = '{1, 1, 1, 1, 1, 1, 0, 0, 1, 1};
  localparam int V_CAS  [NVEC] = '{0, 0, 0, 1, 1, 0, 0, 0, 0, 0};

  logic             clk;
  logic             rst_n;
  logic             cyc_start, cyc_end, page_hit, ref_tick;
  logic [1:0]       fast_mode;
  logic [RCD_W-1:0] rcd_clks;
  logic [CNT_W-1:0] ras_limit;
  logic             ras_act, cas_act, xfer_ack, ref_busy;

  int total, bad;
  int ras_tot, rb_tot, rr_tot;
  bit done;

  dram_fastpath_ctrl #(.CNT_W(CNT_W), .RCD_W(RCD_W), .REF_LEN(REF_LEN)) i_dram_fastpath_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .cyc_start (cyc_start),
    .cyc_end   (cyc_end),
    .page_hit  (page_hit),
    .ref_tick  (ref_tick),
    .fast_mode (fast_mode),
    .rcd_clks  (rcd_clks),
    .ras_limit (ras_limit),
    .ras_act   (ras_act),
    .cas_act   (cas_act),
    .xfer_ack  (xfer_ack),
    .ref_busy  (ref_busy)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // Cycle counters: each posedge counts the cycle that just ended.
  always @(posedge clk) begin
    if (ras_act) ras_tot <= ras_tot + 1;
    if (ref_busy) rb_tot <= rb_tot + 1;
    if (ref_busy && ras_act) rr_tot <= rr_tot + 1;
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Called at a negedge. Starts an access, waits for the acknowledge,
  // ends the cycle and samples the strobes one cycle later.
  task automatic do_acc(input logic hit, input logic tick,
                        output int lat, output int r, output int c, output int rb);
    page_hit  = hit;
    cyc_start = 1'b1;
    ref_tick  = tick;
    lat = 99;
    for (int k = 1; k <= 40; k++) begin
      @(negedge clk);
      cyc_start = 1'b0;
      ref_tick  = 1'b0;
      if (xfer_ack) begin
        lat = k;
        break;
      end
    end
    @(negedge clk);
    cyc_end = 1'b1;
    @(negedge clk);
    cyc_end = 1'b0;
    r  = int'(ras_act);
    c  = int'(cas_act);
    rb = int'(ref_busy);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int lat, r, c, rb, s0, s1, s2;
    total = 0; bad = 0; done = 0;
    ras_tot = 0; rb_tot = 0; rr_tot = 0;
    rst_n = 1'b0; cyc_start = 0; cyc_end = 0; page_hit = 0; ref_tick = 0;
    fast_mode = 2'b01; rcd_clks = RCD_W'(RCD); ras_limit = 8'd255;

    // R1 reset state
    repeat (3) @(negedge clk);
    chk("R1 ras in reset", int'(ras_act), 0);
    chk("R1 cas in reset", int'(cas_act), 0);
    chk("R1 ack in reset", int'(xfer_ack), 0);
    chk("R1 ref in reset", int'(ref_busy), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 idle after release", int'(ras_act | cas_act | xfer_ack | ref_busy), 0);

    // Table of accesses (R2 R3 R4 R5)
    for (int i = 0; i < NVEC; i++) begin
      fast_mode = 2'(V_MODE[i]);
      do_acc(V_HIT[i] != 0, 1'b0, lat, r, c, rb);
      chk($sformatf("R2/R3/R4 latency vec %0d", i), lat, V_LAT[i]);
      chk($sformatf("R5 ras held vec %0d", i), r, V_RAS[i]);
      chk($sformatf("R5 cas held vec %0d", i), c, V_CAS[i]);
      @(negedge clk);
    end

    // R7 R8: refresh from a held row (mode 10 row held now)
    s0 = rb_tot; s1 = rr_tot;
    ref_tick = 1'b1;
    @(negedge clk);
    ref_tick = 1'b0;
    chk("R7 refresh not yet", int'(ref_busy), 0);
    @(negedge clk);
    chk("R7 refresh started", int'(ref_busy), 1);
    chk("R8 cas first", int'(cas_act), 1);
    chk("R8 ras not first", int'(ras_act), 0);
    repeat (7) @(negedge clk);
    chk("R8 busy cycles", rb_tot - s0, REF_LEN + 1);
    chk("R8 ras cycles", rr_tot - s1, REF_LEN);
    chk("R8 strobes released", int'(ras_act | cas_act), 0);

    // R10: hit ignored after refresh
    do_acc(1'b1, 1'b0, lat, r, c, rb);
    chk("R10 full after refresh", lat, RCD + 1);

    // R7: tick during an active cycle, refresh right after cycle end
    fast_mode = 2'b01;
    do_acc(1'b1, 1'b1, lat, r, c, rb);
    chk("R3 fast with tick", lat, 1);
    chk("R7 refresh at cycle end", rb, 1);
    chk("R8 cas first at end", c, 1);
    chk("R8 ras low at end", r, 0);

    // R9: access started in first refresh cycle waits for it
    do_acc(1'b1, 1'b0, lat, r, c, rb);
    chk("R9 ack after refresh", lat, REF_LEN + RCD + 2);
    chk("R10 row held after", r, 1);

    // R6: row timeout
    fast_mode = 2'b00;
    do_acc(1'b0, 1'b0, lat, r, c, rb);
    chk("R4 miss to close", lat, RCD + 2);
    chk("R5 mode 00 closes", r, 0);
    ras_limit = 8'd20;
    fast_mode = 2'b01;
    @(negedge clk);
    s2 = ras_tot;
    do_acc(1'b0, 1'b0, lat, r, c, rb);
    chk("R2 full from idle", lat, RCD + 1);
    repeat (40) @(negedge clk);
    chk("R6 ras low time", ras_tot - s2, 21);
    chk("R6 row closed", int'(ras_act), 0);
    do_acc(1'b1, 1'b0, lat, r, c, rb);
    chk("R6 hit after timeout is full", lat, RCD + 1);
    chk("R6 row held again", r, 1);

    // R1: asynchronous reset while a row is held
    rst_n = 1'b0;
    #1;
    chk("R1 ras on async reset", int'(ras_act), 0);
    chk("R1 ref on async reset", int'(ref_busy), 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule